// File: doc/BRIEF.md
# Dual-Port SRAM Command Scheduler

This block sits between three request sources and a synchronous SRAM that has two bidirectional data ports, A and B, each able to carry one read or one write per cycle. Two sources issue single-word lookup reads: a destination-address lookup and a source-address lookup. The third source issues table updates as a group of four writes that must go out together. Every cycle the scheduler chooses the command for each port. It tracks how long each port has been free of reads, so that a port changes from reading to writing only after its data bus has turned around. It then routes returning read data to the source that asked for it.

The device address bus runs at double data rate. The port A address belongs on the rising edge and the port B address on the falling edge. The block presents these as two single-rate signals, `ma_addr` and `mb_addr`, which feed an output DDR register. All three request inputs use valid/ready. A source holds valid and its payload steady until it sees ready high at a clock edge, and that edge moves the request. The two read ready signals never depend on the source's own payload. Read returns and write data toward the device have no back-pressure: they appear at fixed latencies, and the consumer must take them in that cycle.

A write group waits for a quiet moment. It starts when no lookup is valid, or when it has been held for `MAX_WAIT` cycles. From then on the group is committed, and reads are held off until its burst has gone out.

Top module: `dps_sched`

## Requirements
- R1: After reset, no command is issued and no read return is flagged. Both ports count as fully turned around, so a write group offered alone in the first cycle goes out in that cycle.
- R2: When the scheduler accepts reads and both lookup sources are valid, both go out in the same cycle, one on each port. A lone valid lookup goes out on port A (rising-edge address). `ma_we`/`mb_we` is 0 for a read.
- R3: When both lookups go out together, the first such cycle after reset puts the destination lookup on port A. Each later cycle of that kind swaps the two sources between the ports.
- R4: Read data sampled on a port's `*_rdata` exactly 5 cycles after that port carried a read appears in the same cycle on the output of the source that issued the read, with its valid high. A return valid is high in no other cycle.
- R5: A write group goes out in two consecutive cycles. In the first, port A carries word 0 and port B word 1. In the second, port A carries word 2 and port B word 3. Word k occupies bits [k*AW +: AW] of `wg_addr` and [k*DW +: DW] of `wg_data`. `wg_ready` is high only in the first cycle, and no read goes out in between.
- R6: A port carries a write only when it has carried no read in the 4 cycles before. The burst starts only when both ports meet this.
- R7: A write-to-read change costs nothing: a valid lookup goes out in the cycle right after the second burst cycle.
- R8: Write data leaves on `ma_wdata`/`mb_wdata`, with `ma_wdv`/`mb_wdv` high, exactly 3 cycles after the matching write command, and only then.
- R9: A write group that has been held valid without acceptance for `MAX_WAIT` cycles commits even while lookups are valid.
- R10: A write group commits as soon as it is valid and no lookup is valid. Once it is committed, both read ready signals stay low until its burst starts, even if lookups arrive meanwhile.
- R11: While a committed group waits for turnaround, neither port carries a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Destination lookup request valid |
| da_ready | output | 1 | Destination lookup accepted |
| da_addr | input | AW | Destination lookup address |
| sa_valid | input | 1 | Source lookup request valid |
| sa_ready | output | 1 | Source lookup accepted |
| sa_addr | input | AW | Source lookup address |
| wg_valid | input | 1 | Write group valid |
| wg_ready | output | 1 | Write group accepted (first burst cycle) |
| wg_addr | input | GW*AW | Four write addresses, word 0 in the low bits |
| wg_data | input | GW*DW | Four write data words, word 0 in the low bits |
| ma_cmd | output | 1 | Port A command strobe |
| ma_we | output | 1 | Port A write (1) or read (0) |
| ma_addr | output | AW | Port A address (rising-edge half) |
| ma_wdata | output | DW | Port A write data |
| ma_wdv | output | 1 | Port A write data valid |
| ma_rdata | input | DW | Port A read data |
| mb_cmd | output | 1 | Port B command strobe |
| mb_we | output | 1 | Port B write (1) or read (0) |
| mb_addr | output | AW | Port B address (falling-edge half) |
| mb_wdata | output | DW | Port B write data |
| mb_wdv | output | 1 | Port B write data valid |
| mb_rdata | input | DW | Port B read data |
| da_rvalid | output | 1 | Destination lookup data valid |
| da_rdata | output | DW | Destination lookup data |
| sa_rvalid | output | 1 | Source lookup data valid |
| sa_rdata | output | DW | Source lookup data |

## Verification
A wrong tag in a return slot sends data to the wrong lookup output exactly five cycles after the read, so a comparison on every cycle catches it right away. A turnaround counter that is off shows up as a write strobe one or more cycles early or late, or as ready signals that fall at the wrong time, in the cycle the group would have started. A round-robin or wait counter that is corrupted changes which address appears on port A, or when `wg_ready` rises. That difference appears at the first contention after the fault, and the write-data strobe stays three cycles behind it.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic {SRC_DA = 1'b0, SRC_SA = 1'b1} src_e;
  localparam int NPORT = 2;
endpackage

// File: rtl/dps_turn_trk.sv
// Counts read-free cycles on one port, saturating at the turnaround length.
module dps_turn_trk #(
  parameter int TURN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_issue,
  output logic turned
);
  localparam int CW = $clog2(TURN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= CW'(TURN);
    else if (rd_issue)      cnt_q <= '0;
    else if (cnt_q < CW'(TURN)) cnt_q <= cnt_q + 1'b1;
  end

  assign turned = (cnt_q >= CW'(TURN));
endmodule

// File: rtl/dps_rd_tag.sv
// Carries the requester of each read alongside the device's read latency.
module dps_rd_tag #(
  parameter int LAT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  logic in_src,
  output logic out_vld,
  output logic out_src
);
  logic [LAT-1:0] v_q;
  logic [LAT-1:0] s_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      s_q <= '0;
    end else begin
      v_q <= {v_q[LAT-2:0], in_vld};
      s_q <= {s_q[LAT-2:0], in_src};
    end
  end

  assign out_vld = v_q[LAT-1];
  assign out_src = s_q[LAT-1];
endmodule

// File: rtl/dps_wdelay.sv
// Delays write data to the cycle the device captures it.
module dps_wdelay #(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);
  logic [LAT-1:0]        v_q;
  logic [LAT-1:0][W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      d_q <= '0;
    end else begin
      v_q[0] <= in_vld;
      d_q[0] <= in_vld ? in_data : '0;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign out_vld  = v_q[LAT-1];
  assign out_data = d_q[LAT-1];
endmodule

// File: rtl/dps_arbiter.sv
// Picks per-port commands: lookups round-robin, write groups as one burst.
module dps_arbiter
  import dps_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int GW       = 4,
  parameter int MAX_WAIT = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        da_valid,
  input  logic [AW-1:0]               da_addr,
  input  logic                        sa_valid,
  input  logic [AW-1:0]               sa_addr,
  input  logic                        wg_valid,
  input  logic [GW*AW-1:0]            wg_addr,
  input  logic [GW*DW-1:0]            wg_data,
  input  logic [NPORT-1:0]            turned,
  output logic                        da_ready,
  output logic                        sa_ready,
  output logic                        wg_ready,
  output logic [NPORT-1:0]            p_cmd,
  output logic [NPORT-1:0]            p_we,
  output logic [NPORT-1:0][AW-1:0]    p_addr,
  output logic [NPORT-1:0][DW-1:0]    p_wdata,
  output logic [NPORT-1:0]            p_src
);
  localparam int BEATS = GW / NPORT;
  localparam int BCW   = $clog2(BEATS + 1);
  localparam int WCW   = $clog2(MAX_WAIT + 1);

  logic [BCW-1:0]   beat_q;
  logic             commit_q;
  logic [WCW-1:0]   wait_q;
  logic             rr_q;
  logic [GW*AW-1:0] ga_q;
  logic [GW*DW-1:0] gd_q;

  logic bursting, rd_any, cond, fire, rd_open, both_rd;

  always_comb begin
    bursting = (beat_q != '0);
    rd_any   = da_valid | sa_valid;
    cond     = commit_q | (wg_valid & (~rd_any | (wait_q == WCW'(MAX_WAIT))));
    fire     = ~bursting & cond & (&turned);
    rd_open  = ~bursting & ~cond;
    both_rd  = rd_open & da_valid & sa_valid;
    da_ready = rd_open;
    sa_ready = rd_open;
    wg_ready = fire;

    p_cmd   = '0;
    p_we    = '0;
    p_addr  = '0;
    p_wdata = '0;
    p_src   = '0;

    if (bursting) begin
      for (int p = 0; p < NPORT; p++) begin
        p_cmd[p]   = 1'b1;
        p_we[p]    = 1'b1;
        p_addr[p]  = ga_q[(int'(beat_q) * NPORT + p) * AW +: AW];
        p_wdata[p] = gd_q[(int'(beat_q) * NPORT + p) * DW +: DW];
      end
    end else if (fire) begin
      for (int p = 0; p < NPORT; p++) begin
        p_cmd[p]   = 1'b1;
        p_we[p]    = 1'b1;
        p_addr[p]  = wg_addr[p * AW +: AW];
        p_wdata[p] = wg_data[p * DW +: DW];
      end
    end else if (rd_open) begin
      if (both_rd) begin
        p_cmd     = '1;
        p_src[0]  = rr_q;
        p_src[1]  = ~rr_q;
        p_addr[0] = rr_q ? sa_addr : da_addr;
        p_addr[1] = rr_q ? da_addr : sa_addr;
      end else if (da_valid) begin
        p_cmd[0]  = 1'b1;
        p_src[0]  = SRC_DA;
        p_addr[0] = da_addr;
      end else if (sa_valid) begin
        p_cmd[0]  = 1'b1;
        p_src[0]  = SRC_SA;
        p_addr[0] = sa_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q   <= '0;
      commit_q <= 1'b0;
      wait_q   <= '0;
      rr_q     <= 1'b0;
      ga_q     <= '0;
      gd_q     <= '0;
    end else begin
      if (fire)
        beat_q <= (BEATS > 1) ? BCW'(1) : '0;
      else if (bursting)
        beat_q <= (beat_q == BCW'(BEATS - 1)) ? '0 : beat_q + 1'b1;
      commit_q <= ~bursting & cond & ~fire;
      if (~wg_valid | fire)              wait_q <= '0;
      else if (wait_q != WCW'(MAX_WAIT)) wait_q <= wait_q + 1'b1;
      if (both_rd) rr_q <= ~rr_q;
      if (fire) begin
        ga_q <= wg_addr;
        gd_q <= wg_data;
      end
    end
  end
endmodule

// File: rtl/dps_sched.sv
module dps_sched
  import dps_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int GW       = 4,
  parameter int MAX_WAIT = 8,
  parameter int TURN     = 4,
  parameter int RD_LAT   = 5,
  parameter int WR_LAT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             da_valid,
  output logic             da_ready,
  input  logic [AW-1:0]    da_addr,
  input  logic             sa_valid,
  output logic             sa_ready,
  input  logic [AW-1:0]    sa_addr,
  input  logic             wg_valid,
  output logic             wg_ready,
  input  logic [GW*AW-1:0] wg_addr,
  input  logic [GW*DW-1:0] wg_data,
  output logic             ma_cmd,
  output logic             ma_we,
  output logic [AW-1:0]    ma_addr,
  output logic [DW-1:0]    ma_wdata,
  output logic             ma_wdv,
  input  logic [DW-1:0]    ma_rdata,
  output logic             mb_cmd,
  output logic             mb_we,
  output logic [AW-1:0]    mb_addr,
  output logic [DW-1:0]    mb_wdata,
  output logic             mb_wdv,
  input  logic [DW-1:0]    mb_rdata,
  output logic             da_rvalid,
  output logic [DW-1:0]    da_rdata,
  output logic             sa_rvalid,
  output logic [DW-1:0]    sa_rdata
);
  logic [NPORT-1:0]         turned, p_cmd, p_we, p_src, t_vld, t_src, w_vld;
  logic [NPORT-1:0][AW-1:0] p_addr;
  logic [NPORT-1:0][DW-1:0] p_wdata, w_data, rdat;

  dps_arbiter #(.AW(AW), .DW(DW), .GW(GW), .MAX_WAIT(MAX_WAIT)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .da_valid(da_valid), .da_addr(da_addr),
    .sa_valid(sa_valid), .sa_addr(sa_addr),
    .wg_valid(wg_valid), .wg_addr(wg_addr), .wg_data(wg_data),
    .turned(turned),
    .da_ready(da_ready), .sa_ready(sa_ready), .wg_ready(wg_ready),
    .p_cmd(p_cmd), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_src(p_src)
  );

  assign rdat[0] = ma_rdata;
  assign rdat[1] = mb_rdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dps_turn_trk #(.TURN(TURN)) u_trk (
      .clk(clk), .rst_n(rst_n),
      .rd_issue(p_cmd[p] & ~p_we[p]),
      .turned(turned[p])
    );
    dps_rd_tag #(.LAT(RD_LAT)) u_tag (
      .clk(clk), .rst_n(rst_n),
      .in_vld(p_cmd[p] & ~p_we[p]), .in_src(p_src[p]),
      .out_vld(t_vld[p]), .out_src(t_src[p])
    );
    dps_wdelay #(.W(DW), .LAT(WR_LAT)) u_wd (
      .clk(clk), .rst_n(rst_n),
      .in_vld(p_cmd[p] & p_we[p]), .in_data(p_wdata[p]),
      .out_vld(w_vld[p]), .out_data(w_data[p])
    );
  end

  assign ma_cmd   = p_cmd[0];
  assign ma_we    = p_we[0];
  assign ma_addr  = p_addr[0];
  assign ma_wdata = w_data[0];
  assign ma_wdv   = w_vld[0];
  assign mb_cmd   = p_cmd[1];
  assign mb_we    = p_we[1];
  assign mb_addr  = p_addr[1];
  assign mb_wdata = w_data[1];
  assign mb_wdv   = w_vld[1];

  // Return routing: a source has at most one read per cycle, so at most one port matches.
  always_comb begin
    da_rvalid = 1'b0;
    da_rdata  = '0;
    sa_rvalid = 1'b0;
    sa_rdata  = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (t_vld[p] && t_src[p] == SRC_DA) begin
        da_rvalid = 1'b1;
        da_rdata  = rdat[p];
      end
      if (t_vld[p] && t_src[p] == SRC_SA) begin
        sa_rvalid = 1'b1;
        sa_rdata  = rdat[p];
      end
    end
  end
endmodule

// File: rtl/dps_sched_chk.sv
module dps_sched_chk #(
  parameter int TURN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ma_cmd,
  input logic ma_we,
  input logic mb_cmd,
  input logic mb_we,
  input logic ma_wdv,
  input logic mb_wdv,
  input logic wg_ready,
  input logic da_valid,
  input logic da_ready,
  input logic da_rvalid,
  input logic sa_rvalid
);
  int gap_a, gap_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_a <= TURN;
      gap_b <= TURN;
    end else begin
      gap_a <= (ma_cmd && !ma_we) ? 0 : ((gap_a < TURN) ? gap_a + 1 : gap_a);
      gap_b <= (mb_cmd && !mb_we) ? 0 : ((gap_b < TURN) ? gap_b + 1 : gap_b);
    end
  end

  a_r6_turn_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ma_cmd && ma_we) |-> (gap_a >= TURN));
  a_r6_turn_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_cmd && mb_we) |-> (gap_b >= TURN));
  a_r5_burst: assert property (@(posedge clk) disable iff (!rst_n)
    wg_ready |=> (ma_cmd && ma_we && mb_cmd && mb_we));
  a_r8_wdv_a: assert property (@(posedge clk) disable iff (!rst_n)
    ma_wdv == $past(ma_cmd && ma_we, 3));
  a_r8_wdv_b: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wdv == $past(mb_cmd && mb_we, 3));
  a_r4_da_ret: assert property (@(posedge clk) disable iff (!rst_n)
    da_rvalid |-> ($past(ma_cmd && !ma_we, 5) || $past(mb_cmd && !mb_we, 5)));
  a_r4_sa_ret: assert property (@(posedge clk) disable iff (!rst_n)
    sa_rvalid |-> ($past(ma_cmd && !ma_we, 5) || $past(mb_cmd && !mb_we, 5)));
  a_r2_port_a: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_ready) |-> (ma_cmd && !ma_we));
endmodule

bind dps_sched dps_sched_chk #(.TURN(TURN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ma_cmd(ma_cmd), .ma_we(ma_we), .mb_cmd(mb_cmd), .mb_we(mb_we),
  .ma_wdv(ma_wdv), .mb_wdv(mb_wdv), .wg_ready(wg_ready),
  .da_valid(da_valid), .da_ready(da_ready),
  .da_rvalid(da_rvalid), .sa_rvalid(sa_rvalid)
);

// File: tb/sim_dps_sched.sv
`timescale 1ns/1ps
module sim_dps_sched;
  localparam int AW = 8, DW = 16, GW = 4, MAXW = 8, TURN = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic da_valid = 0, sa_valid = 0, wg_valid = 0;
  logic da_ready, sa_ready, wg_ready;
  logic [AW-1:0] da_addr = '0, sa_addr = '0;
  logic [GW*AW-1:0] wg_addr = '0;
  logic [GW*DW-1:0] wg_data = '0;
  logic ma_cmd, ma_we, ma_wdv, mb_cmd, mb_we, mb_wdv;
  logic [AW-1:0] ma_addr, mb_addr;
  logic [DW-1:0] ma_wdata, mb_wdata, ma_rdata = '0, mb_rdata = '0;
  logic da_rvalid, sa_rvalid;
  logic [DW-1:0] da_rdata, sa_rdata;

  always #5 clk = ~clk;

  dps_sched u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int p_da = 0, p_sa = 0, p_wg = 0;
  bit da_fired = 0, sa_fired = 0, wg_fired = 0;
  bit done = 0;

  // reference model state
  int mem [256];
  int gap [2];
  int beat = 0, waitc = 0, rr = 0, commit = 0, prev_beat = 0;
  int g_a [4], g_d [4];
  int rs_v [2][8], rs_s [2][8], rs_d [2][8];
  int ws_v [2][8], ws_a [2][8], ws_d [2][8];

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  // stimulus: new request only when the previous one was taken (valid/ready)
  always @(posedge clk) begin
    #1;
    ma_rdata <= DW'(rs_d[0][cyc % 8]);
    mb_rdata <= DW'(rs_d[1][cyc % 8]);
    if (rst_n && !done) begin
      if (!da_valid || da_fired) begin
        da_valid <= ($urandom_range(99) < p_da);
        da_addr  <= AW'($urandom);
      end
      if (!sa_valid || sa_fired) begin
        sa_valid <= ($urandom_range(99) < p_sa);
        sa_addr  <= AW'($urandom);
      end
      if (!wg_valid || wg_fired) begin
        wg_valid <= ($urandom_range(99) < p_wg);
        wg_addr  <= {AW'($urandom), AW'($urandom), AW'($urandom), AW'($urandom)};
        wg_data  <= {DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom)};
      end
    end else if (done) begin
      da_valid <= 0; sa_valid <= 0; wg_valid <= 0;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1: nothing issued or returned during reset
      chk("R1", "ma_cmd", ma_cmd, 0);
      chk("R1", "mb_cmd", mb_cmd, 0);
      chk("R1", "da_rvalid", da_rvalid, 0);
      chk("R1", "sa_rvalid", sa_rvalid, 0);
    end else begin
      int e_cmd [2], e_we [2], e_addr [2], e_src [2];
      int rd_any, cond, fire, eready, both;
      int a_cmd [2], a_we [2], a_addr [2], a_wdv [2], a_wd [2];
      int e_dav, e_dad, e_sav, e_sad;
      string tg;
      a_cmd[0] = ma_cmd; a_we[0] = ma_we; a_addr[0] = ma_addr; a_wdv[0] = ma_wdv; a_wd[0] = ma_wdata;
      a_cmd[1] = mb_cmd; a_we[1] = mb_we; a_addr[1] = mb_addr; a_wdv[1] = mb_wdv; a_wd[1] = mb_wdata;
      for (int p = 0; p < 2; p++) begin e_cmd[p] = 0; e_we[p] = 0; e_addr[p] = 0; e_src[p] = 0; end
      rd_any = da_valid || sa_valid;
      cond = commit || (wg_valid && (!rd_any || waitc >= MAXW));
      fire = 0; both = 0;
      if (beat != 0) begin
        tg = "R5";
        for (int p = 0; p < 2; p++) begin e_cmd[p] = 1; e_we[p] = 1; e_addr[p] = g_a[2+p]; end
      end else if (cond) begin
        tg = (commit && rd_any) ? "R10" : (waitc >= MAXW ? "R9" : "R6/R11");
        if (gap[0] >= TURN && gap[1] >= TURN) begin
          fire = 1; tg = (cyc == 0) ? "R1" : "R5";
          for (int k = 0; k < 4; k++) begin
            g_a[k] = int'(wg_addr[k*AW +: AW]);
            g_d[k] = int'(wg_data[k*DW +: DW]);
          end
          for (int p = 0; p < 2; p++) begin e_cmd[p] = 1; e_we[p] = 1; e_addr[p] = g_a[p]; end
        end
      end else begin
        tg = (prev_beat != 0) ? "R7" : "R2";
        if (da_valid && sa_valid) begin
          both = 1; tg = "R3";
          e_cmd[0] = 1; e_cmd[1] = 1;
          e_src[0] = rr; e_src[1] = 1 - rr;
          e_addr[0] = rr ? int'(sa_addr) : int'(da_addr);
          e_addr[1] = rr ? int'(da_addr) : int'(sa_addr);
        end else if (da_valid) begin
          e_cmd[0] = 1; e_src[0] = 0; e_addr[0] = int'(da_addr);
        end else if (sa_valid) begin
          e_cmd[0] = 1; e_src[0] = 1; e_addr[0] = int'(sa_addr);
        end
      end
      eready = (beat == 0) && !cond;
      chk(tg, "da_ready", da_ready, eready);
      chk(tg, "sa_ready", sa_ready, eready);
      chk(tg, "wg_ready", wg_ready, fire);
      for (int p = 0; p < 2; p++) begin
        chk(tg, p ? "mb_cmd" : "ma_cmd", a_cmd[p], e_cmd[p]);
        if (e_cmd[p] != 0) begin
          chk(tg, p ? "mb_we" : "ma_we", a_we[p], e_we[p]);
          chk(tg, p ? "mb_addr" : "ma_addr", a_addr[p], e_addr[p]);
        end
      end
      // R8: write data three cycles after the command
      for (int p = 0; p < 2; p++) begin
        int s;
        s = cyc % 8;
        chk("R8", p ? "mb_wdv" : "ma_wdv", a_wdv[p], ws_v[p][s]);
        if (ws_v[p][s] != 0) begin
          chk("R8", p ? "mb_wdata" : "ma_wdata", a_wd[p], ws_d[p][s]);
          mem[ws_a[p][s]] = ws_d[p][s];
        end
        ws_v[p][s] = 0;
      end
      // R4: returns routed by requester, five cycles after the read
      e_dav = 0; e_dad = 0; e_sav = 0; e_sad = 0;
      for (int p = 0; p < 2; p++) begin
        int s;
        s = cyc % 8;
        if (rs_v[p][s] != 0) begin
          if (rs_s[p][s] == 0) begin e_dav = 1; e_dad = rs_d[p][s]; end
          else begin e_sav = 1; e_sad = rs_d[p][s]; end
        end
        rs_v[p][s] = 0; rs_d[p][s] = 0;
      end
      chk("R4", "da_rvalid", da_rvalid, e_dav);
      chk("R4", "sa_rvalid", sa_rvalid, e_sav);
      if (e_dav != 0) chk("R4", "da_rdata", da_rdata, e_dad);
      if (e_sav != 0) chk("R4", "sa_rdata", sa_rdata, e_sad);
      // schedule device behaviour for this cycle's commands
      for (int p = 0; p < 2; p++) begin
        if (e_cmd[p] != 0 && e_we[p] == 0) begin
          int s;
          s = (cyc + 5) % 8;
          rs_v[p][s] = 1; rs_s[p][s] = e_src[p]; rs_d[p][s] = mem[e_addr[p]];
        end
        if (e_cmd[p] != 0 && e_we[p] != 0) begin
          int s;
          s = (cyc + 3) % 8;
          ws_v[p][s] = 1; ws_a[p][s] = e_addr[p];
          ws_d[p][s] = (beat != 0) ? g_d[2+p] : g_d[p];
        end
      end
      // advance model state
      for (int p = 0; p < 2; p++)
        gap[p] = (e_cmd[p] != 0 && e_we[p] == 0) ? 0 : ((gap[p] < TURN) ? gap[p] + 1 : gap[p]);
      commit = (beat == 0) && cond && !fire;
      prev_beat = beat;
      beat = fire;
      waitc = (!wg_valid || fire) ? 0 : ((waitc < MAXW) ? waitc + 1 : waitc);
      if (both != 0) rr = 1 - rr;
      da_fired = da_valid && da_ready;
      sa_fired = sa_valid && sa_ready;
      wg_fired = wg_valid && wg_ready;
      cyc++;
    end
  end

  task automatic phase(input int d, input int s, input int w, input int n);
    p_da = d; p_sa = s; p_wg = w;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i * 37 + 5) & 16'hffff;
    gap[0] = TURN; gap[1] = TURN;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 8; s++) begin
        rs_v[p][s] = 0; rs_s[p][s] = 0; rs_d[p][s] = 0;
        ws_v[p][s] = 0; ws_a[p][s] = 0; ws_d[p][s] = 0;
      end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    phase(0, 0, 100, 6);      // R1 immediate write after reset, back-to-back groups
    phase(100, 100, 0, 12);   // R2 R3 both lookups every cycle
    phase(100, 0, 0, 6);      // R2 lone destination lookup on port A
    phase(0, 100, 0, 6);      // R2 lone source lookup on port A
    phase(0, 0, 100, 20);     // R6 R11 turnaround, R5 bursts
    phase(100, 100, 100, 60); // R9 starvation limit, R7 reads after burst
    phase(30, 30, 100, 200);  // R10 commit holds off late reads
    phase(40, 40, 10, 2000);  // mixed traffic
    done = 1;
    repeat (12) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule